// File: doc/BRIEF.md
# Short-Address Single-Channel DMA Engine

This block is one DMA channel that works in short-address form. It keeps a 24-bit memory-side pointer and an 8-bit I/O-side pointer. Each request it accepts moves one byte or one 16-bit word between the two sides. A down-counter sets how many such moves make up a job. The source that activates the channel fixes the direction of the move. Only the serial receive-full event moves data from the I/O side into memory. Every other source moves data from memory to the I/O side.

Software programs the channel through a four-entry register port. Index 0 holds the memory pointer, index 1 the I/O pointer, index 2 the count and index 3 the control word. Writing the memory pointer or the count loads both the working copy and the reload copy. Reads return the working copies. The control word is laid out as follows: bit 0 enable, bit 1 interrupt enable, bit 2 word size (1 = word), bit 3 decrement (1 = step down), bits 5:4 mode, bits 8:6 source.

The mode field selects one of three modes:
- 0: I/O mode.
- 1: idle mode.
- 2: repeat mode.
- 3: behaves like idle mode.

The source field selects the activating event:
- 0 to 3: timer channels 0 to 3.
- 4: serial transmit-empty.
- 5: serial receive-full.
- 6: external request pin.
- 7: no source.

The bus side performs one read cycle followed by one write cycle. The data read is held in a register between the two cycles.

The controller has three states:
- `ST_IDLE`: waits for a pending request while the channel is enabled.
- `ST_READ`: drives the source address with a read strobe and captures the read data.
- `ST_WRITE`: drives the destination address, the write strobe and the captured data. At the end of this state the pointer and count are updated.

The transitions are:
- `ST_IDLE` to `ST_READ` on take (pending request and enable both set).
- `ST_READ` to `ST_WRITE` unconditionally.
- `ST_WRITE` to `ST_IDLE` unconditionally.

Top module: `sdma_channel`

## Requirements
- R1: After reset, all four register indices read zero, `bus_rd`, `bus_wr` and `irq` are low.
- R2: Each accepted request gives one cycle with `bus_rd` high, then one cycle with `bus_wr` high. The write carries the data read in the previous cycle. When control bit 2 is 1, all 16 bits are carried. When control bit 2 is 0, only the low 8 bits are carried and the upper byte of `bus_wdata` is zero.
- R3: With source 5 (receive-full), the read goes to the I/O page and the write goes to the memory pointer. With every other source, the read goes to the memory pointer and the write goes to the I/O page.
- R4: The I/O page address is the 8-bit I/O pointer with all 16 upper bits set to one.
- R5: In I/O mode and repeat mode, each transfer steps the memory pointer by 1 for a byte or by 2 for a word. It steps up when control bit 3 is 0 and down when control bit 3 is 1. The I/O pointer never changes.
- R6: In idle mode, the memory pointer stays unchanged across all transfers.
- R7: Each transfer lowers the count by one. In I/O and idle modes, the transfer that brings the count to zero clears control bit 0. After that, requests are ignored until software sets bit 0 again.
- R8: In I/O and idle modes, `irq` pulses high for one cycle after the final transfer when control bit 1 is 1. It stays low when control bit 1 is 0.
- R9: In repeat mode, the final transfer restores the programmed memory pointer and count. The channel stays enabled and `irq` never rises.
- R10: Requests that arrive while a request is already pending or a transfer is running merge into one pending request. Such a request is serviced after the current transfer, unless the channel has just disabled itself, in which case it is dropped.
- R11: Only the selected source activates the channel. The external pin (source 6) works only when `IS_B_CHANNEL` is 1. Source 7 never activates the channel.
- R12: While control bit 0 is 0, no request starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| tmr_evt | input | 4 | Timer compare/capture A events, channels 0 to 3 |
| sci_txe | input | 1 | Serial transmit-empty event |
| sci_rxf | input | 1 | Serial receive-full event |
| ext_req | input | 1 | External request pin |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_word | output | 1 | Access is a 16-bit word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The two functions that can coincide are the arrival of a new request and the completion of the final count, because both can happen in the cycle of the last write. The bench provokes this by holding an event high for three cycles, so that the event covers the final transfer. It does this once in repeat mode, where the merged request must be serviced at the reloaded pointer, and once in I/O mode, where the request must be dropped. The scoreboard counts the bus writes in each case and compares them with the expected addresses, so a missing transfer and an extra transfer are both reported.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        MODE_IO   = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_RPT  = 2'd2,
        MODE_RSV  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    typedef struct packed {
        logic [2:0] src;
        mode_e      mode;
        logic       dec;
        logic       word;
        logic       ie;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W  = 9;
    localparam int TMR_CH  = 4;

    localparam logic [2:0] SRC_TXE = 3'd4;
    localparam logic [2:0] SRC_RXF = 3'd5;
    localparam logic [2:0] SRC_EXT = 3'd6;

    localparam logic [1:0] IDX_MEM  = 2'd0;
    localparam logic [1:0] IDX_IO   = 2'd1;
    localparam logic [1:0] IDX_CNT  = 2'd2;
    localparam logic [1:0] IDX_CTRL = 2'd3;

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              en_clr,
    output ctrl_t             ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(ctrl_wdata);
        end else if (en_clr) begin
            ctrl_q.en <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/sdma_req.sv
module sdma_req
    import sdma_pkg::*;
#(
    parameter bit IS_B_CHANNEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_CH-1:0] tmr_evt,
    input  logic              sci_txe,
    input  logic              sci_rxf,
    input  logic              ext_req,
    input  logic [2:0]        src,
    input  logic              en,
    input  logic              take,
    output logic              pend,
    output logic              io_to_mem
);

    logic ext_ok;
    logic hit;
    logic pend_q;

    generate
        if (IS_B_CHANNEL) begin : g_ext
            assign ext_ok = ext_req;
        end else begin : g_noext
            assign ext_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (src)
            3'd0, 3'd1, 3'd2, 3'd3: hit = tmr_evt[src[1:0]];
            SRC_TXE:                hit = sci_txe;
            SRC_RXF:                hit = sci_rxf;
            SRC_EXT:                hit = ext_ok;
            default:                hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!en) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    assign pend      = pend_q;
    assign io_to_mem = (src == SRC_RXF);

    // R12: a disabled channel holds no pending request
    a_r12_no_pend_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pend_q);

endmodule

// File: rtl/sdma_addr.sv
module sdma_addr
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr,
    input  logic              io_wr,
    input  logic              cnt_wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    input  mode_e             mode,
    input  logic              word,
    input  logic              dec,
    output logic [ADDR_W-1:0] mem_cur,
    output logic [IO_W-1:0]   io_q,
    output logic [CNT_W-1:0]  cnt_cur,
    output logic              last
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] mem_init;
    logic [CNT_W-1:0]  cnt_init;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] mem_next;
    logic              moving;

    assign last   = (cnt_cur == CNT_ONE);
    assign stride = word ? ADDR_W'(2) : ADDR_W'(1);
    assign moving = (mode == MODE_IO) || (mode == MODE_RPT);

    always_comb begin
        if (mode == MODE_RPT && last) begin
            mem_next = mem_init;
        end else if (moving) begin
            mem_next = dec ? (mem_cur - stride) : (mem_cur + stride);
        end else begin
            mem_next = mem_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_init <= '0;
            mem_cur  <= '0;
        end else if (mem_wr) begin
            mem_init <= wdata;
            mem_cur  <= wdata;
        end else if (step) begin
            mem_cur  <= mem_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_q <= '0;
        end else if (io_wr) begin
            io_q <= wdata[IO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_init <= '0;
            cnt_cur  <= '0;
        end else if (cnt_wr) begin
            cnt_init <= wdata[CNT_W-1:0];
            cnt_cur  <= wdata[CNT_W-1:0];
        end else if (step) begin
            if (mode == MODE_RPT && last) begin
                cnt_cur <= cnt_init;
            end else begin
                cnt_cur <= cnt_cur - CNT_ONE;
            end
        end
    end

    // R6: idle mode leaves the memory pointer where it is
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_IDLE && !mem_wr) |=> (mem_cur == $past(mem_cur)));

    // R9: the final repeat transfer brings back the programmed count
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && mode == MODE_RPT && !cnt_wr) |=> (cnt_cur == cnt_init));

endmodule

// File: rtl/sdma_channel.sv
module sdma_channel
    import sdma_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int IO_W         = 8,
    parameter int CNT_W        = 16,
    parameter int DATA_W       = 16,
    parameter bit IS_B_CHANNEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [TMR_CH-1:0] tmr_evt,
    input  logic              sci_txe,
    input  logic              sci_rxf,
    input  logic              ext_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int PAGE_W = ADDR_W - IO_W;
    localparam int BYTE_W = DATA_W / 2;

    state_e            state_q;
    state_e            state_d;
    ctrl_t             ctrl;
    logic              ctrl_wr;
    logic              mem_wr;
    logic              io_wr;
    logic              cnt_wr;
    logic              pend;
    logic              io_to_mem;
    logic              take;
    logic              step;
    logic              done;
    logic              en_clr;
    logic              irq_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] mem_cur;
    logic [IO_W-1:0]   io_q;
    logic [CNT_W-1:0]  cnt_cur;
    logic              last;
    logic [ADDR_W-1:0] io_full;

    assign ctrl_wr = reg_we && (reg_addr == IDX_CTRL);
    assign mem_wr  = reg_we && (reg_addr == IDX_MEM);
    assign io_wr   = reg_we && (reg_addr == IDX_IO);
    assign cnt_wr  = reg_we && (reg_addr == IDX_CNT);

    sdma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
        .en_clr     (en_clr),
        .ctrl_o     (ctrl)
    );

    sdma_req #(.IS_B_CHANNEL(IS_B_CHANNEL)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_evt   (tmr_evt),
        .sci_txe   (sci_txe),
        .sci_rxf   (sci_rxf),
        .ext_req   (ext_req),
        .src       (ctrl.src),
        .en        (ctrl.en),
        .take      (take),
        .pend      (pend),
        .io_to_mem (io_to_mem)
    );

    sdma_addr #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_wr  (mem_wr),
        .io_wr   (io_wr),
        .cnt_wr  (cnt_wr),
        .wdata   (reg_wdata),
        .step    (step),
        .mode    (ctrl.mode),
        .word    (ctrl.word),
        .dec     (ctrl.dec),
        .mem_cur (mem_cur),
        .io_q    (io_q),
        .cnt_cur (cnt_cur),
        .last    (last)
    );

    assign io_full = {{PAGE_W{1'b1}}, io_q};
    assign take    = (state_q == ST_IDLE) && pend && ctrl.en;
    assign step    = (state_q == ST_WRITE);
    assign done    = step && last;
    assign en_clr  = done && (ctrl.mode != MODE_RPT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (state_q == ST_READ) data_q <= bus_rdata;
            irq_q <= done && ctrl.ie && (ctrl.mode != MODE_RPT);
        end
    end

    // bus outputs
    always_comb begin
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_word  = 1'b0;
        bus_wdata = '0;
        unique case (state_q)
            ST_READ: begin
                bus_rd   = 1'b1;
                bus_word = ctrl.word;
                bus_addr = io_to_mem ? io_full : mem_cur;
            end
            ST_WRITE: begin
                bus_wr    = 1'b1;
                bus_word  = ctrl.word;
                bus_addr  = io_to_mem ? mem_cur : io_full;
                bus_wdata = ctrl.word ? data_q : {{(DATA_W-BYTE_W){1'b0}}, data_q[BYTE_W-1:0]};
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (reg_addr)
            IDX_MEM:  reg_rdata = mem_cur;
            IDX_IO:   reg_rdata = ADDR_W'(io_q);
            IDX_CNT:  reg_rdata = ADDR_W'(cnt_cur);
            default:  reg_rdata = ADDR_W'(ctrl);
        endcase
    end

    assign irq = irq_q;

    // R2: strobes never overlap, and a write always follows a read
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

    // R9: repeat mode never interrupts
    a_r9_quiet_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ctrl.mode) != MODE_RPT));

    // R7: the final transfer in I/O or idle mode disables the channel
    a_r7_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl.mode != MODE_RPT && !ctrl_wr) |=> !ctrl.en);

endmodule

// File: tb/sdma_channel_test.sv
module sdma_channel_test;

    typedef struct packed {
        logic [23:0] a;
        logic [15:0] d;
        logic        w;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [3:0]  tmr_evt = '0;
    logic        sci_txe = 1'b0;
    logic        sci_rxf = 1'b0;
    logic        ext_req = 1'b0;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_word;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq;

    int    errors = 0;
    int    checks = 0;
    int    irq_cnt = 0;
    bit    finished = 1'b0;
    xfer_t exp_q[$];

    always #5 clk = ~clk;

    sdma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_evt(tmr_evt),
        .sci_txe(sci_txe), .sci_rxf(sci_rxf), .ext_req(ext_req),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic logic [15:0] mval(input logic [23:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign bus_rdata = mval(bus_addr);

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each bus write with the scoreboard
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (rst_n && bus_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R12 unexpected write", {bus_addr, bus_wdata}, 40'h0);
            end else begin
                xfer_t e;
                e = exp_q.pop_front();
                check(bus_addr == e.a, "R3/R4/R5 write address", 40'(bus_addr), 40'(e.a));
                check(bus_wdata == e.d && bus_word == e.w, "R2 write data", {bus_word, bus_wdata}, {e.w, e.d});
            end
        end
    end

    task automatic wreg(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [23:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [23:0] src, input logic [23:0] dst, input bit w);
        xfer_t e;
        e.a = dst;
        e.d = w ? mval(src) : {8'h00, mval(src)[7:0]};
        e.w = w;
        exp_q.push_back(e);
    endtask

    // code: 0..3 timer, 4 txe, 5 rxf, 6 ext; held for n cycles
    task automatic evt(input int code, input int n);
        @(negedge clk);
        if (code < 4) tmr_evt[code] = 1'b1;
        else if (code == 4) sci_txe = 1'b1;
        else if (code == 5) sci_rxf = 1'b1;
        else ext_req = 1'b1;
        repeat (n) @(negedge clk);
        tmr_evt = '0; sci_txe = 1'b0; sci_rxf = 1'b0; ext_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [23:0] ctl(input bit en, input bit ie, input bit w, input bit dc,
                                       input logic [1:0] md, input logic [2:0] s);
        return {15'd0, s, md, dc, w, ie, en};
    endfunction

    task automatic drained(input string tag);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, 40'(exp_q.size()), 40'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        int irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rreg(2'(i), v);
            check(v == 24'h0, "R1 register reset", 40'(v), 40'h0);
        end
        check(!bus_rd && !bus_wr && !irq, "R1 bus idle", {bus_rd, bus_wr, irq}, 40'h0);

        // I/O mode, byte, increment, transmit-empty: memory -> I/O page
        wreg(2'd0, 24'h001000); wreg(2'd1, 24'h000040); wreg(2'd2, 24'd3);
        wreg(2'd3, ctl(1, 1, 0, 0, 2'd0, 3'd4));
        irq0 = irq_cnt;
        for (int k = 0; k < 3; k++) begin
            push(24'h001000 + 24'(k), 24'hFFFF40, 1'b0);
            evt(4, 1);
        end
        drained("R2 R3 transfers done");
        rreg(2'd0, v); check(v == 24'h001003, "R5 byte increment", 40'(v), 40'h001003);
        rreg(2'd1, v); check(v == 24'h000040, "R5 io pointer kept", 40'(v), 40'h40);
        rreg(2'd2, v); check(v == 24'h0, "R7 count zero", 40'(v), 40'h0);
        rreg(2'd3, v); check(v[0] == 1'b0, "R7 enable cleared", 40'(v[0]), 40'h0);
        check(irq_cnt == irq0 + 1, "R8 irq once", 40'(irq_cnt - irq0), 40'h1);
        evt(4, 1);
        drained("R7 request after finish ignored");

        // I/O mode, word, decrement, receive-full: I/O page -> memory, no irq
        wreg(2'd0, 24'h002000); wreg(2'd1, 24'h000080); wreg(2'd2, 24'd2);
        wreg(2'd3, ctl(1, 0, 1, 1, 2'd0, 3'd5));
        irq0 = irq_cnt;
        push(24'hFFFF80, 24'h002000, 1'b1); evt(5, 1);
        push(24'hFFFF80, 24'h001FFE, 1'b1); evt(5, 1);
        drained("R3 receive direction");
        rreg(2'd0, v); check(v == 24'h001FFC, "R5 word decrement", 40'(v), 40'h001FFC);
        check(irq_cnt == irq0, "R8 irq masked", 40'(irq_cnt - irq0), 40'h0);

        // idle mode, word, timer channel 2; unselected timer ignored
        wreg(2'd0, 24'h003000); wreg(2'd1, 24'h000010); wreg(2'd2, 24'd2);
        wreg(2'd3, ctl(1, 1, 1, 0, 2'd1, 3'd2));
        irq0 = irq_cnt;
        evt(1, 1);
        drained("R11 unselected timer ignored");
        push(24'h003000, 24'hFFFF10, 1'b1); evt(2, 1);
        push(24'h003000, 24'hFFFF10, 1'b1); evt(2, 1);
        drained("R6 idle transfers");
        rreg(2'd0, v); check(v == 24'h003000, "R6 pointer fixed", 40'(v), 40'h003000);
        check(irq_cnt == irq0 + 1, "R8 irq in idle mode", 40'(irq_cnt - irq0), 40'h1);

        // repeat mode, byte, external pin
        wreg(2'd0, 24'h004000); wreg(2'd1, 24'h000020); wreg(2'd2, 24'd2);
        wreg(2'd3, ctl(1, 1, 0, 0, 2'd2, 3'd6));
        irq0 = irq_cnt;
        push(24'h004000, 24'hFFFF20, 1'b0); evt(6, 1);
        push(24'h004001, 24'hFFFF20, 1'b0); evt(6, 1);
        push(24'h004000, 24'hFFFF20, 1'b0); evt(6, 1);
        drained("R9 repeat transfers");
        rreg(2'd0, v); check(v == 24'h004001, "R9 pointer reloaded", 40'(v), 40'h004001);
        rreg(2'd2, v); check(v == 24'd1, "R9 count reloaded", 40'(v), 40'h1);
        rreg(2'd3, v); check(v[0] == 1'b1, "R9 stays enabled", 40'(v[0]), 40'h1);
        check(irq_cnt == irq0, "R9 no irq", 40'(irq_cnt - irq0), 40'h0);

        // R10 request held across the final repeat transfer: two transfers
        push(24'h004001, 24'hFFFF20, 1'b0);
        push(24'h004000, 24'hFFFF20, 1'b0);
        evt(6, 3);
        drained("R10 merged request serviced after reload");
        rreg(2'd0, v); check(v == 24'h004001, "R10 pointer after merge", 40'(v), 40'h004001);

        // R10 request held across the final I/O transfer: dropped
        wreg(2'd0, 24'h005000); wreg(2'd1, 24'h000030); wreg(2'd2, 24'd1);
        wreg(2'd3, ctl(1, 0, 0, 0, 2'd0, 3'd4));
        push(24'h005000, 24'hFFFF30, 1'b0);
        evt(4, 3);
        drained("R10 request dropped at self-disable");
        rreg(2'd0, v); check(v == 24'h005001, "R10 single transfer", 40'(v), 40'h005001);

        // R12 disabled channel
        wreg(2'd2, 24'd4);
        wreg(2'd3, ctl(0, 0, 0, 0, 2'd0, 3'd4));
        evt(4, 2);
        drained("R12 disabled ignores requests");
        rreg(2'd2, v); check(v == 24'd4, "R12 count untouched", 40'(v), 40'h4);

        // R11 source 7 never activates
        wreg(2'd3, ctl(1, 0, 0, 0, 2'd0, 3'd7));
        for (int c = 0; c < 7; c++) evt(c, 1);
        drained("R11 source 7 inert");
        rreg(2'd2, v); check(v == 24'd4, "R11 count untouched", 40'(v), 40'h4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule